// File: doc/BRIEF.md
# Phase-Selectable I2C Bit Shifter

This block moves one 9-bit frame over an SCL/SDA pair: eight data bits followed by an acknowledge bit, most significant bit first. It drives SCL itself, timing each half period from a baud-rate tick input. A start pulse loads the byte and the acknowledge bit. The block then drives the frame on SDA, samples the incoming line on every rising SCL edge, copies the received bits into a receive buffer and raises a one-cycle transfer interrupt.

When both I2C enables are set, a phase input picks one of two timings. Phase 0 starts with SCL high and leaves it low after the frame. The interrupt fires on the ninth rising edge, and the buffer is loaded once, on the falling edge that follows. Phase 1 starts and ends with SCL low and adds a tenth clock. The interrupt fires on the tenth falling edge, and the buffer is loaded twice: once with the first eight bits and once with the full frame. If either enable is clear, the block works as a plain clocked serial port and ignores the phase input.

A 3-bit delay setting can hold back changes on SDA by a set number of baud ticks, counted through a tick-driven pipeline.

Top module: `iic_phase_shifter`

## Requirements
- R1: While reset is held and after it is released, the outputs are SCL = 1, SDA = 1, busy = 0, interrupt = 0 and receive buffer = 0.
- R2: In phase 0 with both enables set, SCL is high when the frame starts. The frame has 9 rising and 10 falling SCL edges, and SCL stays low after the frame. While idle, SCL does not change.
- R3: In phase 1 with both enables set, SCL is low when the frame starts. The frame has 10 rising and 10 falling SCL edges, and SCL stays low after the frame.
- R4: In phase 0, the interrupt is a single-cycle pulse. It is raised on the same clock edge as the 9th rising SCL edge, after 9 falling edges.
- R5: In phase 1, the interrupt is a single-cycle pulse raised on the same clock edge as the 10th falling SCL edge. It is raised only at the end of a frame.
- R6: In phase 0, the receive buffer is loaded exactly once per frame, on the falling SCL edge after the 9th rising edge. At the interrupt it still holds its previous value, and it never changes while idle.
- R7: In phase 1, the receive buffer is loaded twice per frame. The first load is on the 8th falling SCL edge and gives {0, first eight sampled bits}. The second load is on the 9th rising SCL edge and gives all nine sampled bits.
- R8: The transmitted frame is {tx_data[7:0], tx_ack}, MSB first, and SDA changes only while SCL is low. Received bits enter at the LSB on rising SCL edges, so rx_buf[8:1] holds the data and rx_buf[0] holds the acknowledge bit.
- R9: If iic_en or iic_en2 is 0, phase_sel is ignored. SCL is high before and after the frame, there are 9 rising and 9 falling edges, and the interrupt and the buffer load both occur on the 9th rising edge.
- R10: Delay setting 0 means SDA follows the shifter directly. A setting d from 1 to 7 delays every SDA change by d+1 baud ticks. In phase 0, the first SDA change therefore appears 1 tick after launch with d = 0, and d+2 ticks after launch otherwise.
- R11: The delay setting is captured at launch. A change during a frame takes effect only from the next frame.
- R12: busy rises in the cycle after an accepted start and stays high until the last SCL edge of the frame. A start that arrives while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| baud_tick | input | 1 | One-cycle pulse per SCL half period |
| iic_en | input | 1 | First I2C mode enable |
| iic_en2 | input | 1 | Second I2C mode enable |
| phase_sel | input | 1 | Clock-phase select (used only when both enables are set) |
| sda_dly | input | DLY_W | SDA delay setting |
| start | input | 1 | Launch pulse |
| tx_data | input | DATA_W | Byte to transmit |
| tx_ack | input | 1 | Acknowledge bit to transmit |
| sda_in | input | 1 | Sampled SDA line |
| scl_out | output | 1 | Generated SCL |
| sda_out | output | 1 | Driven SDA value |
| busy | output | 1 | Frame in progress |
| xfer_irq | output | 1 | Transfer interrupt pulse |
| rx_buf | output | DATA_W+1 | Receive buffer |

## Verification
The assertions assume that the baud tick is an isolated one-cycle pulse with at least one idle cycle between ticks. They also assume that start is never asserted during reset. The bench generates the tick every fourth clock and leaves start low until reset is released. The properties also assume that the enables and phase_sel are read only at launch, so the bench changes them only between frames. The one exception is the deliberate mid-frame change of the delay setting and of start.

// File: rtl/iic_shifter_pkg.sv
package iic_shifter_pkg;

  typedef enum logic [1:0] {
    MODE_PLAIN = 2'd0,
    MODE_PH0   = 2'd1,
    MODE_PH1   = 2'd2
  } xfer_mode_e;

  function automatic xfer_mode_e pick_mode(input logic en_a, input logic en_b,
                                           input logic ph);
    if (!(en_a && en_b)) return MODE_PLAIN;
    return ph ? MODE_PH1 : MODE_PH0;
  endfunction

endpackage

// File: rtl/iic_step_seq.sv
// Half-period step counter: generates SCL and the per-step event strobes.
module iic_step_seq
  import iic_shifter_pkg::*;
#(
  parameter int FRAME_BITS = 9
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       baud_tick,
  input  logic       start,
  input  xfer_mode_e mode_req,
  output logic       busy,
  output logic       scl,
  output logic       launch,
  output logic       ev_present,
  output logic       ev_release,
  output logic       ev_sample,
  output logic       ev_load,
  output logic       ev_irq
);
  localparam int LAST_STEP = 2 * FRAME_BITS + 2;
  localparam int STEP_W    = $clog2(LAST_STEP + 1);
  localparam logic [STEP_W-1:0] S_PRE  = STEP_W'(2 * FRAME_BITS - 2);
  localparam logic [STEP_W-1:0] S_ODDL = STEP_W'(2 * FRAME_BITS - 1);
  localparam logic [STEP_W-1:0] S_DATA = STEP_W'(2 * FRAME_BITS);
  localparam logic [STEP_W-1:0] S_TAIL = STEP_W'(2 * FRAME_BITS + 1);
  localparam logic [STEP_W-1:0] S_XTRA = STEP_W'(2 * FRAME_BITS + 2);

  logic [STEP_W-1:0] step_q;
  logic [STEP_W-1:0] step_nx;
  xfer_mode_e        mode_q;
  logic              adv;
  logic              odd;
  logic              fall_edge;
  logic              done;

  assign launch = start & ~busy;

  always_comb begin
    adv        = busy & baud_tick;
    step_nx    = step_q + 1'b1;
    odd        = step_nx[0];
    fall_edge  = odd;
    ev_present = 1'b0;
    ev_release = 1'b0;
    ev_sample  = 1'b0;
    ev_load    = 1'b0;
    ev_irq     = 1'b0;
    done       = 1'b0;
    unique case (mode_q)
      MODE_PH1: begin
        // rest low: odd steps rise (sample), even steps fall (present)
        fall_edge  = ~odd;
        ev_sample  = adv & odd & (step_nx <= S_ODDL);
        ev_present = adv & ~odd & (step_nx <= S_PRE);
        ev_release = adv & (step_nx == S_DATA);
        ev_load    = adv & ((step_nx == S_PRE) | (step_nx == S_ODDL));
        ev_irq     = adv & (step_nx == S_XTRA);
        done       = ev_irq;
      end
      MODE_PH0: begin
        ev_present = adv & odd & (step_nx <= S_ODDL);
        ev_sample  = adv & ~odd & (step_nx <= S_DATA);
        ev_irq     = adv & (step_nx == S_DATA);
        ev_load    = adv & (step_nx == S_TAIL);
        ev_release = ev_load;
        done       = ev_load;
      end
      default: begin
        ev_present = adv & odd & (step_nx <= S_ODDL);
        ev_sample  = adv & ~odd & (step_nx <= S_DATA);
        ev_irq     = adv & (step_nx == S_DATA);
        ev_load    = ev_irq;
        ev_release = ev_irq;
        done       = ev_irq;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      scl    <= 1'b1;
      step_q <= '0;
      mode_q <= MODE_PLAIN;
    end else if (launch) begin
      busy   <= 1'b1;
      step_q <= '0;
      mode_q <= mode_req;
      scl    <= (mode_req != MODE_PH1);
    end else if (adv) begin
      step_q <= step_nx;
      scl    <= ~fall_edge;
      if (done) busy <= 1'b0;
    end
  end

endmodule

// File: rtl/iic_bit_path.sv
// Transmit shifter, receive shifter and receive buffer.
module iic_bit_path #(
  parameter int FRAME_BITS = 9
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  launch,
  input  logic                  launch_ph1,
  input  logic [FRAME_BITS-1:0] frame_in,
  input  logic                  sda_in,
  input  logic                  ev_present,
  input  logic                  ev_release,
  input  logic                  ev_sample,
  input  logic                  ev_load,
  output logic                  sda_bit,
  output logic [FRAME_BITS-1:0] rx_buf
);
  logic [FRAME_BITS-1:0] tx_sh;
  logic [FRAME_BITS-1:0] rx_sh;
  logic [FRAME_BITS-1:0] rx_nx;

  // a sample and a load can share one step; the load must see the new bit
  assign rx_nx = ev_sample ? {rx_sh[FRAME_BITS-2:0], sda_in} : rx_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sh   <= '0;
      sda_bit <= 1'b1;
    end else if (launch) begin
      // phase 1 presents its first bit before the first rising edge
      tx_sh   <= launch_ph1 ? {frame_in[FRAME_BITS-2:0], 1'b0} : frame_in;
      sda_bit <= launch_ph1 ? frame_in[FRAME_BITS-1] : 1'b1;
    end else if (ev_present) begin
      sda_bit <= tx_sh[FRAME_BITS-1];
      tx_sh   <= {tx_sh[FRAME_BITS-2:0], 1'b0};
    end else if (ev_release) begin
      sda_bit <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_sh  <= '0;
      rx_buf <= '0;
    end else if (launch) begin
      rx_sh <= '0;
    end else begin
      if (ev_sample) rx_sh  <= rx_nx;
      if (ev_load)   rx_buf <= rx_nx;
    end
  end

endmodule

// File: rtl/iic_sda_delay.sv
// Tick-clocked SDA delay line with a setting captured at launch.
module iic_sda_delay #(
  parameter int DLY_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             baud_tick,
  input  logic             launch,
  input  logic [DLY_W-1:0] cfg_in,
  input  logic             sda_bit,
  output logic             sda_out
);
  localparam int DEPTH = 2 ** DLY_W;

  logic [DEPTH-1:0] pipe;
  logic [DLY_W-1:0] cfg_q;

  always_ff @(posedge clk) begin
    if (rst)         cfg_q <= '0;
    else if (launch) cfg_q <= cfg_in;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst)            pipe[g] <= 1'b1;
        else if (baud_tick) pipe[g] <= sda_bit;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst)            pipe[g] <= 1'b1;
        else if (baud_tick) pipe[g] <= pipe[g-1];
      end
    end
  end

  // stage k lags the shifter by k+1 ticks, so setting d taps stage d
  assign sda_out = (cfg_q == '0) ? sda_bit : pipe[cfg_q];

endmodule

// File: rtl/iic_phase_shifter.sv
module iic_phase_shifter
  import iic_shifter_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DLY_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              baud_tick,
  input  logic              iic_en,
  input  logic              iic_en2,
  input  logic              phase_sel,
  input  logic [DLY_W-1:0]  sda_dly,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_ack,
  input  logic              sda_in,
  output logic              scl_out,
  output logic              sda_out,
  output logic              busy,
  output logic              xfer_irq,
  output logic [DATA_W:0]   rx_buf
);
  localparam int FRAME_BITS = DATA_W + 1;

  xfer_mode_e mode_req;
  logic launch;
  logic ev_present, ev_release, ev_sample, ev_load, ev_irq;
  logic sda_bit;

  assign mode_req = pick_mode(iic_en, iic_en2, phase_sel);

  iic_step_seq #(.FRAME_BITS(FRAME_BITS)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .baud_tick  (baud_tick),
    .start      (start),
    .mode_req   (mode_req),
    .busy       (busy),
    .scl        (scl_out),
    .launch     (launch),
    .ev_present (ev_present),
    .ev_release (ev_release),
    .ev_sample  (ev_sample),
    .ev_load    (ev_load),
    .ev_irq     (ev_irq)
  );

  iic_bit_path #(.FRAME_BITS(FRAME_BITS)) u_bits (
    .clk        (clk),
    .rst        (rst),
    .launch     (launch),
    .launch_ph1 (mode_req == MODE_PH1),
    .frame_in   ({tx_data, tx_ack}),
    .sda_in     (sda_in),
    .ev_present (ev_present),
    .ev_release (ev_release),
    .ev_sample  (ev_sample),
    .ev_load    (ev_load),
    .sda_bit    (sda_bit),
    .rx_buf     (rx_buf)
  );

  iic_sda_delay #(.DLY_W(DLY_W)) u_dly (
    .clk       (clk),
    .rst       (rst),
    .baud_tick (baud_tick),
    .launch    (launch),
    .cfg_in    (sda_dly),
    .sda_bit   (sda_bit),
    .sda_out   (sda_out)
  );

  // registered on the same edge that moves SCL
  always_ff @(posedge clk) begin
    if (rst) xfer_irq <= 1'b0;
    else     xfer_irq <= ev_irq;
  end

endmodule

// File: rtl/iic_phase_shifter_chk.sv
module iic_phase_shifter_chk #(
  parameter int DATA_W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            baud_tick,
  input logic            start,
  input logic            busy,
  input logic            scl_out,
  input logic            xfer_irq,
  input logic [DATA_W:0] rx_buf
);

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    xfer_irq |=> !xfer_irq); // R4

  AST_IRQ_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    xfer_irq |-> $past(busy)); // R5

  AST_SCL_REST: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy) && !$past(start)) |-> $stable(scl_out)); // R2

  AST_RXBUF_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy)) |-> $stable(rx_buf)); // R6

  AST_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy); // R12

  AST_BUSY_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
    (busy && !baud_tick) |=> busy); // R12

endmodule

bind iic_phase_shifter iic_phase_shifter_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .baud_tick (baud_tick),
  .start     (start),
  .busy      (busy),
  .scl_out   (scl_out),
  .xfer_irq  (xfer_irq),
  .rx_buf    (rx_buf)
);

// File: tb/iic_phase_shifter_test.sv
module iic_phase_shifter_test;
  localparam int CLK_PERIOD  = 10;
  localparam int TICK_DIV    = 4;
  localparam int NB          = 9;
  localparam int WDOG_CYCLES = 100000;

  logic clk = 1'b0;
  logic rst, baud_tick = 1'b0, iic_en, iic_en2, phase_sel, start, tx_ack, sda_in;
  logic [2:0] sda_dly;
  logic [7:0] tx_data;
  logic scl_out, sda_out, busy, xfer_irq;
  logic [8:0] rx_buf;

  int checks = 0, failures = 0;
  bit finished = 1'b0;

  // monitor state
  int tick_cnt = 0, rise_cnt = 0, fall_cnt = 0, irq_cnt = 0, rxb_chg = 0;
  int irq_rise = 0, irq_fall = 0, irq_scl = 0, irq_rxb = 0, sda_fall_tick = 0, div = 0;
  logic scl_q = 1'b1, sda_q = 1'b1;
  logic [8:0] rxb_q = '0;
  logic [8:0] rxb_hist [16];

  // per-frame bases
  int b_rise = 0, b_fall = 0, b_irq = 0, b_chg = 0, b_tick = 0, init_scl = 0;
  bit loop_en = 1'b1;
  logic [8:0] rx_pat = '0;
  int idx;

  always #(CLK_PERIOD/2) clk = ~clk;

  iic_phase_shifter uut (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .iic_en(iic_en), .iic_en2(iic_en2),
    .phase_sel(phase_sel), .sda_dly(sda_dly), .start(start), .tx_data(tx_data),
    .tx_ack(tx_ack), .sda_in(sda_in), .scl_out(scl_out), .sda_out(sda_out),
    .busy(busy), .xfer_irq(xfer_irq), .rx_buf(rx_buf)
  );

  always_comb begin
    idx = rise_cnt - b_rise;
    if (loop_en)                sda_in = sda_out;
    else if (idx >= 0 && idx < NB) sda_in = rx_pat[NB-1-idx];
    else                        sda_in = 1'b1;
  end

  always @(negedge clk) begin
    if (baud_tick) tick_cnt++;
    if (scl_out && !scl_q) rise_cnt++;
    if (!scl_out && scl_q) fall_cnt++;
    if (!sda_out && sda_q) sda_fall_tick = tick_cnt;
    if (xfer_irq) begin
      irq_cnt++; irq_rise = rise_cnt; irq_fall = fall_cnt;
      irq_scl = int'(scl_out); irq_rxb = int'(rx_buf);
    end
    if (rx_buf != rxb_q) begin
      rxb_hist[rxb_chg % 16] = rx_buf;
      rxb_chg++;
    end
    scl_q = scl_out; sda_q = sda_out; rxb_q = rx_buf;
    div = (div + 1) % TICK_DIV;
    baud_tick = (div == 0);
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_frame(input logic en2, input logic ph, input logic [2:0] dly,
                           input logic [7:0] data, input logic ack, input bit loop,
                           input logic [8:0] pat, input int mid_tick,
                           input bit mid_start, input logic [2:0] mid_dly);
    @(negedge clk);
    iic_en2 = en2; phase_sel = ph; sda_dly = dly; tx_data = data; tx_ack = ack;
    loop_en = loop; rx_pat = pat; start = 1'b1;
    @(negedge clk); start = 1'b0; #1;
    b_rise = rise_cnt; b_fall = fall_cnt; b_irq = irq_cnt; b_chg = rxb_chg;
    b_tick = tick_cnt; init_scl = int'(scl_out);
    if (mid_tick >= 0) begin
      while (tick_cnt < b_tick + mid_tick) begin @(negedge clk); #1; end
      sda_dly = mid_dly;
      if (mid_start) begin
        tx_data = 8'hFF; start = 1'b1;
        @(negedge clk); #1; start = 1'b0;
      end
    end
    while (busy) begin @(negedge clk); #1; end
    repeat (4) @(negedge clk);
    #1;
  endtask

  task automatic gap();
    repeat (60) @(negedge clk);
  endtask

  task automatic test_reset();
    chk("R1 scl", int'(scl_out), 1);
    chk("R1 sda", int'(sda_out), 1);
    chk("R1 busy", int'(busy), 0);
    chk("R1 irq", int'(xfer_irq), 0);
    chk("R1 rx_buf", int'(rx_buf), 0);
  endtask

  task automatic test_phase0();
    run_frame(1'b1, 1'b0, 3'd0, 8'hA5, 1'b0, 1'b1, 9'h0, -1, 1'b0, 3'd0);
    chk("R2 initial scl", init_scl, 1);
    chk("R2 rises", rise_cnt - b_rise, 9);
    chk("R2 falls", fall_cnt - b_fall, 10);
    chk("R2 final scl", int'(scl_out), 0);
    chk("R4 irq count", irq_cnt - b_irq, 1);
    chk("R4 irq at rise", irq_rise - b_rise, 9);
    chk("R4 irq after falls", irq_fall - b_fall, 9);
    chk("R4 scl at irq", irq_scl, 1);
    chk("R6 buffer at irq", irq_rxb, 0);
    chk("R6 loads", rxb_chg - b_chg, 1);
    chk("R8 loopback frame", int'(rx_buf), 9'h14A);
    chk("R12 busy after", int'(busy), 0);
    gap();
  endtask

  task automatic test_phase1();
    run_frame(1'b1, 1'b1, 3'd0, 8'h5A, 1'b1, 1'b0, 9'h13C, -1, 1'b0, 3'd0);
    chk("R3 initial scl", init_scl, 0);
    chk("R3 rises", rise_cnt - b_rise, 10);
    chk("R3 falls", fall_cnt - b_fall, 10);
    chk("R3 final scl", int'(scl_out), 0);
    chk("R5 irq count", irq_cnt - b_irq, 1);
    chk("R5 irq rises", irq_rise - b_rise, 10);
    chk("R5 irq falls", irq_fall - b_fall, 10);
    chk("R5 scl at irq", irq_scl, 0);
    chk("R7 loads", rxb_chg - b_chg, 2);
    chk("R7 first load", int'(rxb_hist[b_chg % 16]), 9'h09E);
    chk("R7 second load", int'(rxb_hist[(b_chg + 1) % 16]), 9'h13C);
    chk("R8 sampled pattern", int'(rx_buf), 9'h13C);
    gap();
  endtask

  task automatic test_plain();
    run_frame(1'b0, 1'b1, 3'd0, 8'h3C, 1'b1, 1'b1, 9'h0, -1, 1'b0, 3'd0);
    chk("R9 initial scl", init_scl, 1);
    chk("R9 rises", rise_cnt - b_rise, 9);
    chk("R9 falls", fall_cnt - b_fall, 9);
    chk("R9 final scl", int'(scl_out), 1);
    chk("R9 irq rises", irq_rise - b_rise, 9);
    chk("R9 irq falls", irq_fall - b_fall, 9);
    chk("R9 loads", rxb_chg - b_chg, 1);
    chk("R9 rx", int'(rx_buf), 9'h079);
    gap();
    iic_en2 = 1'b1;
  endtask

  task automatic test_delay();
    for (int c = 0; c < 8; c += 3) begin
      run_frame(1'b1, 1'b0, 3'(c), 8'h00, 1'b1, 1'b1, 9'h0, -1, 1'b0, 3'd0);
      chk("R10 sda lag", sda_fall_tick - b_tick, (c == 0) ? 1 : c + 2);
      gap();
    end
  endtask

  task automatic test_dly_latch();
    run_frame(1'b1, 1'b0, 3'd0, 8'h00, 1'b1, 1'b1, 9'h0, 0, 1'b0, 3'd7);
    chk("R11 change mid-frame ignored", sda_fall_tick - b_tick, 1);
    gap();
    run_frame(1'b1, 1'b0, 3'd7, 8'h00, 1'b1, 1'b1, 9'h0, -1, 1'b0, 3'd0);
    chk("R11 new setting next frame", sda_fall_tick - b_tick, 9);
    gap();
  endtask

  task automatic test_busy_start();
    run_frame(1'b1, 1'b0, 3'd0, 8'h3C, 1'b1, 1'b1, 9'h0, 5, 1'b1, 3'd0);
    chk("R12 rx kept", int'(rx_buf), 9'h079);
    chk("R12 rises", rise_cnt - b_rise, 9);
    chk("R12 falls", fall_cnt - b_fall, 10);
    chk("R12 irq count", irq_cnt - b_irq, 1);
    repeat (20) @(negedge clk);
    #1;
    chk("R12 no relaunch", int'(busy), 0);
  endtask

  initial begin
    rst = 1'b1; start = 1'b0; iic_en = 1'b1; iic_en2 = 1'b1; phase_sel = 1'b0;
    sda_dly = 3'd0; tx_data = 8'h00; tx_ack = 1'b0;
    repeat (5) @(negedge clk);
    #1;
    test_reset();
    rst = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    test_reset();
    test_phase0();
    test_phase1();
    test_plain();
    test_delay();
    test_dly_latch();
    test_busy_start();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=%0d expected=%0d", WDOG_CYCLES, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule